// File: doc/BRIEF.md
# FIFO Read Port with Fall-Through and Echo Enable

This block is the read side of a FIFO. It owns the output data register, the read address into the storage array, and the flags and strobes that a reader sees. The pointer logic supplies a count of the words in the storage array. The port answers with a one-cycle pop pulse each time it takes a word, and the read address steps at the same time. The storage array, the write side and any clock-domain crossing sit outside the block.

The port has two modes, and the mode is latched while reset is high. In standard mode a word is fetched only on an enabled read. In fall-through mode the head word moves into the output register by itself, and an enabled read replaces it with the next word. A registered echo enable goes low for exactly one cycle after each load of the output register, so downstream logic knows when a fresh word is present. The data bus is modelled as a value plus a drive-enable. It is driven only while both the active-low chip select and the active-low output enable are low.

Top module: `rdport_fwft_echo`

## Requirements
- R1: While `rst` is high at a clock edge, the output register clears to zero, `echo_n` is set high and `vacant` is set high.
- R2: The mode is taken from `fwft_sel` while `rst` is high (1 = fall-through, 0 = standard). Changes on `fwft_sel` after reset have no effect.
- R3: In standard mode `echo_n` is registered. It goes low after an edge where `rd_cs_n`=0, `rd_en_n`=0 and `occ_count`≠0, and high after any other edge.
- R4: In standard mode a word is loaded into the output register, and `mem_pop` is asserted, only when chip select and read enable are both low and `occ_count` is nonzero.
- R5: In standard mode `vacant` is registered as "the count minus this cycle's pop is zero". It rises on the edge that takes the last stored word.
- R6: In fall-through mode, while `vacant` is high and `occ_count`≠0, the head word is loaded without any read enable, even with `rd_cs_n` high. `vacant` falls and `echo_n` is low for that one cycle.
- R7: In fall-through mode an enabled read (`rd_cs_n`=0, `rd_en_n`=0) while a word is held and `occ_count`≠0 loads the next word and drives `echo_n` low.
- R8: In fall-through mode the first enabled read with a held word and `occ_count`=0 sets `vacant` high and keeps `echo_n` high. The output register keeps its contents.
- R9: After any edge that does not load the output register, `echo_n` is high and `q` is unchanged.
- R10: `q_oe` is 1 exactly when `rd_cs_n` and `out_en_n` are both 0. `q` holds the register contents whatever `q_oe` is.
- R11: In fall-through mode the port together with a storage array of `DEPTH` words holds `DEPTH`+1 words, and they are delivered in write order.
- R12: `mem_addr` starts at 0, advances by one on each `mem_pop`, and wraps from `DEPTH`-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset |
| fwft_sel | input | 1 | Mode select sampled during reset (1 = fall-through) |
| rd_cs_n | input | 1 | Active-low read chip select |
| rd_en_n | input | 1 | Active-low read enable |
| out_en_n | input | 1 | Active-low output enable |
| occ_count | input | CNT_W | Words held in the storage array |
| mem_addr | output | AW | Read address into the storage array |
| mem_rdata | input | DATA_W | Read data at `mem_addr` |
| mem_pop | output | 1 | One-cycle pulse: a word is taken from storage |
| q | output | DATA_W | Output register contents |
| q_oe | output | 1 | Drive enable for `q` |
| echo_n | output | 1 | Active-low echo: a new word was loaded on the last edge |
| vacant | output | 1 | Empty flag (standard) or not-ready flag (fall-through) |

## Verification
Standard mode is driven from a vector table that interleaves writes with reads. The reads are tried with chip select high, with read enable high, with output enable high, and against an empty store. This separates the echo's three-input gating from the count's lag behind writes. Fall-through mode is driven first with chip select high, so that the autonomous load is visibly distinct from an enabled read. It is then driven through a read past the last word, which separates "no word left" from "no load this cycle". A final fill of depth-plus-one words, read back in order across the address wrap, tells a correct extra stage apart from one that loses or repeats a word.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic pop;
        logic vacant_nxt;
    } fetch_dec_t;

    function automatic fetch_dec_t decide_std(input logic rd_req, input logic have,
                                              input logic last);
        fetch_dec_t d;
        d.pop        = rd_req && have;
        d.vacant_nxt = !have || (d.pop && last);
        return d;
    endfunction

    function automatic fetch_dec_t decide_fwft(input logic rd_req, input logic have,
                                               input logic hold);
        fetch_dec_t d;
        d.pop        = have && (!hold || rd_req);
        d.vacant_nxt = !(d.pop || (hold && !rd_req));
        return d;
    endfunction

endpackage

// File: rtl/rdport_addr.sv
module rdport_addr #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            addr <= '0;
        else if (pop)
            addr <= (addr == LAST) ? '0 : addr + 1'b1;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        pop |=> addr == (($past(addr) == LAST) ? '0 : $past(addr) + 1'b1)); // R12

    AST_ADDR_STILL: assert property (@(posedge clk) disable iff (rst)
        !pop |=> $stable(addr)); // R12

endmodule

// File: rtl/rdport_ctrl.sv
module rdport_ctrl
    import rdport_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fwft_sel,
    input  logic             rd_cs_n,
    input  logic             rd_en_n,
    input  logic [CNT_W-1:0] count,
    output logic             pop,
    output logic             vacant,
    output rd_mode_e         mode
);
    logic       rd_req;
    logic       have;
    logic       last;
    fetch_dec_t dec;

    assign rd_req = !rd_cs_n && !rd_en_n;
    assign have   = (count != '0);
    assign last   = (count == CNT_W'(1));

    always_comb begin
        if (mode == MODE_FWFT)
            dec = decide_fwft(rd_req, have, !vacant);
        else
            dec = decide_std(rd_req, have, last);
    end

    assign pop = dec.pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= rd_mode_e'(fwft_sel);
            vacant <= 1'b1;
        end else begin
            vacant <= dec.vacant_nxt;
        end
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> count != '0); // R4

    AST_STD_GATED: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && pop) |-> (!rd_cs_n && !rd_en_n)); // R4

    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && vacant && count != '0) |-> pop); // R6

    AST_MODE_FIXED: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode)); // R2

endmodule

// File: rtl/rdport_outreg.sv
module rdport_outreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              rd_cs_n,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] q,
    output logic              q_oe,
    output logic              echo_n
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            echo_n <= 1'b1;
        end else begin
            echo_n <= !load;
            if (load)
                q <= din;
        end
    end

    assign q_oe = !rd_cs_n && !out_en_n;

    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        echo_n |-> $stable(q)); // R9

endmodule

// File: rtl/rdport_fwft_echo.sv
module rdport_fwft_echo
    import rdport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fwft_sel,
    input  logic              rd_cs_n,
    input  logic              rd_en_n,
    input  logic              out_en_n,
    input  logic [CNT_W-1:0]  occ_count,
    output logic [AW-1:0]     mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_pop,
    output logic [DATA_W-1:0] q,
    output logic              q_oe,
    output logic              echo_n,
    output logic              vacant
);
    rd_mode_e mode;

    rdport_ctrl #(.CNT_W(CNT_W)) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .fwft_sel (fwft_sel),
        .rd_cs_n  (rd_cs_n),
        .rd_en_n  (rd_en_n),
        .count    (occ_count),
        .pop      (mem_pop),
        .vacant   (vacant),
        .mode     (mode)
    );

    rdport_addr #(.DEPTH(DEPTH)) addr_i (
        .clk  (clk),
        .rst  (rst),
        .pop  (mem_pop),
        .addr (mem_addr)
    );

    rdport_outreg #(.DATA_W(DATA_W)) out_i (
        .clk      (clk),
        .rst      (rst),
        .load     (mem_pop),
        .din      (mem_rdata),
        .rd_cs_n  (rd_cs_n),
        .out_en_n (out_en_n),
        .q        (q),
        .q_oe     (q_oe),
        .echo_n   (echo_n)
    );

    AST_FWFT_ECHO_READY: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && !echo_n) |-> !vacant); // R7

    AST_STD_ECHO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && !echo_n) |-> $past(!rd_cs_n && !rd_en_n && occ_count != '0)); // R3

endmodule

// File: tb/rdport_fwft_echo_tb_top.sv
`timescale 1ns/1ps
module rdport_fwft_echo_tb_top;
    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int AW = 2;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fwft_sel = 1'b0;
    logic rd_cs_n = 1'b1, rd_en_n = 1'b1, out_en_n = 1'b0;
    logic wr = 1'b0;
    logic [CW-1:0] count_r;
    logic [AW-1:0] wp, mem_addr;
    logic [DW-1:0] wnum;
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] q;
    logic mem_pop, q_oe, echo_n, vacant;
    logic wacc;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rdport_fwft_echo #(.DATA_W(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .fwft_sel(fwft_sel), .rd_cs_n(rd_cs_n),
        .rd_en_n(rd_en_n), .out_en_n(out_en_n), .occ_count(count_r),
        .mem_addr(mem_addr), .mem_rdata(mem[mem_addr]), .mem_pop(mem_pop),
        .q(q), .q_oe(q_oe), .echo_n(echo_n), .vacant(vacant)
    );

    // storage and pointer model: writes carry 8'hA0 + running write number
    assign wacc = wr && (count_r < CW'(DEPTH));
    always @(posedge clk) begin
        if (rst) begin
            count_r <= '0;
            wp      <= '0;
            wnum    <= '0;
        end else begin
            if (wacc) begin
                mem[wp] <= 8'hA0 + wnum;
                wp      <= wp + 1'b1;
                wnum    <= wnum + 1'b1;
            end
            count_r <= count_r + CW'(wacc) - CW'(mem_pop);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic m);
        rst = 1'b1; fwft_sel = m; wr = 1'b0;
        rd_cs_n = 1'b1; rd_en_n = 1'b1; out_en_n = 1'b0;
        tick(); tick();
        rst = 1'b0;
        fwft_sel = !m; // R2: must be ignored from here on
        chk("R1 echo", 32'(echo_n), 32'd1);
        chk("R1 vacant", 32'(vacant), 32'd1);
        chk("R1 q", 32'(q), 32'd0);
        chk("R12 addr", 32'(mem_addr), 32'd0);
    endtask

    // wr cs_n ren_n oe_n | echo vacant q_oe | q
    localparam logic [14:0] TBL [0:9] = '{
        {7'b1000_111, 8'h00},
        {7'b1010_101, 8'h00},
        {7'b0000_001, 8'hA0},
        {7'b0100_100, 8'hA0},
        {7'b0000_011, 8'hA1},
        {7'b0000_111, 8'hA1},
        {7'b1000_111, 8'hA1},
        {7'b1000_011, 8'hA2},
        {7'b0011_100, 8'hA2},
        {7'b0000_011, 8'hA3}
    };

    task automatic fstep(input logic w, input logic cs, input logic re,
                         input logic e_echo, input logic e_vac, input logic [7:0] e_q,
                         input string tag);
        wr = w; rd_cs_n = cs; rd_en_n = re;
        tick();
        chk({tag, " echo"}, 32'(echo_n), 32'(e_echo));
        chk({tag, " vacant"}, 32'(vacant), 32'(e_vac));
        chk({tag, " q"}, 32'(q), 32'(e_q));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // standard mode, vector table (R3 R4 R5 R9 R10 R12, R2 with fwft_sel flipped high)
        do_reset(1'b0);
        for (int i = 0; i < 10; i++) begin
            wr = TBL[i][14]; rd_cs_n = TBL[i][13]; rd_en_n = TBL[i][12]; out_en_n = TBL[i][11];
            tick();
            chk($sformatf("R3 echo row%0d", i), 32'(echo_n), 32'(TBL[i][10]));
            chk($sformatf("R5 vacant row%0d", i), 32'(vacant), 32'(TBL[i][9]));
            chk($sformatf("R10 q_oe row%0d", i), 32'(q_oe), 32'(TBL[i][8]));
            chk($sformatf("R4 q row%0d", i), 32'(q), 32'(TBL[i][7:0]));
        end
        chk("R12 wrap", 32'(mem_addr), 32'd0);

        // fall-through mode
        do_reset(1'b1);
        fstep(1, 1, 1, 1, 1, 8'h00, "R9 idle");
        fstep(0, 1, 1, 0, 0, 8'hA0, "R6 autoload");
        chk("R10 cs high", 32'(q_oe), 32'd0);
        fstep(0, 1, 1, 1, 0, 8'hA0, "R9 no load");
        fstep(0, 0, 1, 1, 0, 8'hA0, "R9 cs low");
        chk("R10 driven", 32'(q_oe), 32'd1);
        out_en_n = 1'b1; #0.1;
        chk("R10 oe high", 32'(q_oe), 32'd0);
        chk("R10 q kept", 32'(q), 32'hA0);
        out_en_n = 1'b0;
        fstep(1, 0, 1, 1, 0, 8'hA0, "R9 write only");
        fstep(1, 0, 0, 0, 0, 8'hA1, "R7 read");
        fstep(0, 0, 0, 0, 0, 8'hA2, "R7 read2");
        fstep(0, 0, 0, 1, 1, 8'hA2, "R8 past last");
        fstep(0, 0, 0, 1, 1, 8'hA2, "R8 stays empty");

        // capacity: DEPTH+1 words with the read side idle
        for (int k = 0; k < DEPTH + 1; k++) begin
            wr = 1'b1; rd_cs_n = 1'b1; rd_en_n = 1'b1;
            tick();
            if (k == 1) chk("R6 autoload cs high", 32'(echo_n), 32'd0);
        end
        wr = 1'b0;
        chk("R11 store full", 32'(count_r), 32'(DEPTH));
        chk("R11 head", 32'(q), 32'hA3);
        chk("R11 ready", 32'(vacant), 32'd0);
        for (int k = 1; k <= DEPTH; k++)
            fstep(0, 0, 0, 0, 0, 8'(8'hA3 + k), "R11 drain");
        fstep(0, 0, 0, 1, 1, 8'hA7, "R8 drained");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule